// File: doc/BRIEF.md
# Script Block-Move Address Former

This unit sits beside the instruction fetch of a SCSI script processor. When a block-move instruction arrives, it decodes the first instruction dword and the address dword. It then forms the DMA start address (low and high 32-bit words), the byte count and the address of the instruction itself.

Depending on the addressing bits and on the mode controls, it issues at most one read through a valid/ready memory port. That read is one of three kinds:
- a 32-bit pointer dword (indirect addressing);
- an 8-byte descriptor taken from a table relative to the data-structure base (table-indirect addressing);
- a third instruction dword that carries the upper address word (direct 64-bit mode).

In table-indirect 64-bit mode, a field of the descriptor picks one register out of an external register file, and that register supplies the upper address word. The unit finishes with a one-cycle `done` pulse. It separately flags a phase mismatch, in which case the transfer is not started.

Top module: `bmove_addr_unit`

## Requirements
- R1: A synchronous active-high `rst` returns the unit to idle. It clears every registered output and the held table high word, and leaves `mem_req_valid` low.
- R2: The first instruction dword is decoded as follows:
  - bits 23:0 are the byte count;
  - bits 26:24 are the expected bus phase;
  - bit 29 selects indirect addressing and takes priority over bit 28, which selects table-indirect addressing.
  With neither bit set, the low address is the address dword, and no read is made unless direct 64-bit mode is on.
- R3: Indirect addressing makes a single 32-bit read (`mem_req_wide`=0) at the address dword. The low address is response bits 31:0.
- R4: Table-indirect addressing sign-extends bits 23:0 of the address dword and adds the result to `ds_base`. It then makes one 8-byte read (`mem_req_wide`=1) at that address. Response bits 31:0 are the descriptor's first dword and bits 63:32 its second. The byte count is the first dword's bits 23:0, and the low address is the second dword.
- R5: With `en_40bit` set, a table-indirect move takes its high word from first-dword bits 31:24, zero-extended. This setting wins over `en_ti64`.
- R6: With `en_ti64` set (and `en_40bit` clear), first-dword bits 28:24 drive `rf_sel`, and the value on `rf_data` becomes the high word. The external register file maps selector codes as follows:
  - codes 0x00–0x0F select scratch registers 2–17;
  - codes 0x10–0x15 select the memory-read, memory-write, script-fetch, dynamic-register, static-block-move and dynamic-block-move selectors.
- R7: A selector above 0x15 sets `sel_error` for that instruction. The table high word then keeps the value left by the previous instruction.
- R8: Direct 64-bit mode applies with `en_d64` set and neither addressing bit set. The unit reads a 32-bit word at `script_ptr` and pulses `dbm_wr_en` with that word, and `script_ptr_next` becomes `script_ptr`+4. `insn_addr` is always `script_ptr`−8, which equals the advanced pointer minus 12 in this mode.
- R9: The high word follows a fixed priority:
  - if `en_40bit` or `en_ti64` is set, the table-derived word is used (zero for moves that are not table-indirect);
  - otherwise the dynamic-block-move selector is used if nonzero (the freshly read third dword in direct 64-bit mode, else `dbms_in`);
  - otherwise `sbms_in`.
- R10: If the sampled `cur_phase` differs from instruction bits 26:24, `phase_mismatch` is set with `done`, and `xfer_go` stays low. Otherwise `xfer_go` pulses with `done`.
- R11: At most one read is outstanding. A request holds its address and width until `mem_req_ready`, and no request is active in the cycle `done` is high. `done` lasts one cycle, and the results change only in that cycle.
- R12: The mode controls, `cur_phase`, `dbms_in` and `sbms_in` are sampled with `start`. Later changes do not affect the instruction in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin decoding; accepted only while idle |
| insn_word | input | 32 | First instruction dword |
| addr_word | input | 32 | Address dword |
| script_ptr | input | 32 | Script pointer after the two dwords |
| ds_base | input | 32 | Data-structure base address |
| en_40bit | input | 1 | 40-bit table addressing mode |
| en_ti64 | input | 1 | Table-indirect 64-bit mode |
| en_d64 | input | 1 | Direct 64-bit mode |
| cur_phase | input | 3 | Current bus phase |
| dbms_in | input | 32 | Dynamic-block-move selector register |
| sbms_in | input | 32 | Static-block-move selector register |
| rf_sel | output | 5 | Register file read selector |
| rf_data | input | 32 | Register file read data for `rf_sel` |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 32 | Read byte address |
| mem_req_wide | output | 1 | 1: 8-byte read, 0: 4-byte read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data, first dword in bits 31:0 |
| dbm_wr_en | output | 1 | Write strobe for the dynamic-block-move selector |
| dbm_wr_data | output | 32 | Value to write there |
| dma_addr_lo | output | 32 | DMA address bits 31:0 |
| dma_addr_hi | output | 32 | DMA address bits 63:32 |
| byte_count | output | 24 | Transfer byte count |
| insn_addr | output | 32 | Address of the block-move instruction |
| script_ptr_next | output | 32 | Script pointer after this instruction |
| phase_mismatch | output | 1 | Phase field differed from bus phase |
| sel_error | output | 1 | Illegal high-word selector |
| xfer_go | output | 1 | Start the transfer (one cycle) |
| done | output | 1 | Results valid (one cycle) |

## Verification
The hardest situation to reach is the illegal selector, because its expected high word is whatever an earlier table-indirect 64-bit move left behind. The stimulus therefore runs a legal selector-0x15 move immediately before the illegal one and expects that register's value again. A further move with a legal selector must then clear the error. A second awkward case is a mode change in the middle of an instruction. The bench drops `en_40bit` one cycle after `start`, while the descriptor read is still pending, and still expects the descriptor byte as the high word.

// File: rtl/bmove_addr_unit.sv
module bmove_addr_unit #(
  parameter int AW      = 32,
  parameter int CW      = 24,
  parameter int SELW    = 5,
  parameter int MAX_SEL = 21
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [31:0]     insn_word,
  input  logic [AW-1:0]   addr_word,
  input  logic [AW-1:0]   script_ptr,
  input  logic [AW-1:0]   ds_base,
  input  logic            en_40bit,
  input  logic            en_ti64,
  input  logic            en_d64,
  input  logic [2:0]      cur_phase,
  input  logic [AW-1:0]   dbms_in,
  input  logic [AW-1:0]   sbms_in,
  output logic [SELW-1:0] rf_sel,
  input  logic [AW-1:0]   rf_data,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [AW-1:0]   mem_req_addr,
  output logic            mem_req_wide,
  input  logic            mem_rsp_valid,
  input  logic [2*AW-1:0] mem_rsp_data,
  output logic            dbm_wr_en,
  output logic [AW-1:0]   dbm_wr_data,
  output logic [AW-1:0]   dma_addr_lo,
  output logic [AW-1:0]   dma_addr_hi,
  output logic [CW-1:0]   byte_count,
  output logic [AW-1:0]   insn_addr,
  output logic [AW-1:0]   script_ptr_next,
  output logic            phase_mismatch,
  output logic            sel_error,
  output logic            xfer_go,
  output logic            done
);
  localparam int HB = AW - CW;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WAIT, S_SEL, S_FIN} st_t;
  st_t st;

  logic [31:0]     insn_q;
  logic [AW-1:0]   addr_q, sp_q, req_addr_q, dbm_q, sbm_q, hi_tab_q;
  logic [2*AW-1:0] ent_q;
  logic            m40_q, mti_q, md64_q, wide_q, sel_bad_q;
  logic [2:0]      phase_q;

  wire in_ind   = insn_word[29];
  wire in_tab   = !insn_word[29] && insn_word[28];
  wire q_ind    = insn_q[29];
  wire q_tab    = !insn_q[29] && insn_q[28];
  wire q_d64    = md64_q && !insn_q[29] && !insn_q[28];
  wire q_tisel  = q_tab && mti_q && !m40_q;

  wire [AW-1:0] tab_off  = {{HB{addr_word[CW-1]}}, addr_word[CW-1:0]};
  wire [AW-1:0] tab_addr = ds_base + tab_off;

  logic [AW-1:0] hi_tab_now, hi_final;
  always_comb begin
    if (q_tab && m40_q)   hi_tab_now = {{(AW-8){1'b0}}, ent_q[31:24]};
    else if (q_tisel)     hi_tab_now = hi_tab_q;
    else                  hi_tab_now = '0;
    if (m40_q || mti_q)   hi_final = hi_tab_now;
    else if (dbm_q != '0) hi_final = dbm_q;
    else                  hi_final = sbm_q;
  end

  assign mem_req_valid = (st == S_REQ);
  assign mem_req_addr  = req_addr_q;
  assign mem_req_wide  = wide_q;
  assign rf_sel        = ent_q[24 +: SELW];

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      insn_q <= '0; addr_q <= '0; sp_q <= '0; req_addr_q <= '0;
      dbm_q <= '0; sbm_q <= '0; hi_tab_q <= '0; ent_q <= '0;
      m40_q <= 1'b0; mti_q <= 1'b0; md64_q <= 1'b0; wide_q <= 1'b0;
      sel_bad_q <= 1'b0; phase_q <= '0;
      dbm_wr_en <= 1'b0; dbm_wr_data <= '0;
      dma_addr_lo <= '0; dma_addr_hi <= '0; byte_count <= '0;
      insn_addr <= '0; script_ptr_next <= '0;
      phase_mismatch <= 1'b0; sel_error <= 1'b0; xfer_go <= 1'b0; done <= 1'b0;
    end else begin
      done      <= 1'b0;
      xfer_go   <= 1'b0;
      dbm_wr_en <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          insn_q    <= insn_word;
          addr_q    <= addr_word;
          sp_q      <= script_ptr;
          m40_q     <= en_40bit;
          mti_q     <= en_ti64;
          md64_q    <= en_d64;
          phase_q   <= cur_phase;
          dbm_q     <= dbms_in;
          sbm_q     <= sbms_in;
          sel_bad_q <= 1'b0;
          wide_q    <= in_tab;
          if (in_ind)      req_addr_q <= addr_word;
          else if (in_tab) req_addr_q <= tab_addr;
          else             req_addr_q <= script_ptr;
          st <= (in_ind || in_tab || en_d64) ? S_REQ : S_FIN;
        end
        S_REQ: if (mem_req_ready) st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          ent_q <= mem_rsp_data;
          if (q_d64) begin
            dbm_q       <= mem_rsp_data[AW-1:0];
            dbm_wr_en   <= 1'b1;
            dbm_wr_data <= mem_rsp_data[AW-1:0];
          end
          st <= q_tisel ? S_SEL : S_FIN;
        end
        S_SEL: begin
          if (int'(rf_sel) <= MAX_SEL) hi_tab_q <= rf_data;
          else                         sel_bad_q <= 1'b1;
          st <= S_FIN;
        end
        default: begin
          if (!q_tisel) hi_tab_q <= hi_tab_now;
          dma_addr_hi     <= hi_final;
          dma_addr_lo     <= q_ind ? ent_q[AW-1:0] : (q_tab ? ent_q[2*AW-1:AW] : addr_q);
          byte_count      <= q_tab ? ent_q[CW-1:0] : insn_q[CW-1:0];
          insn_addr       <= sp_q - AW'(8);
          script_ptr_next <= q_d64 ? sp_q + AW'(4) : sp_q;
          phase_mismatch  <= (phase_q != insn_q[26:24]);
          xfer_go         <= (phase_q == insn_q[26:24]);
          sel_error       <= q_tisel && sel_bad_q;
          done            <= 1'b1;
          st              <= S_IDLE;
        end
      endcase
    end
  end
endmodule

module bmove_addr_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        en_40bit,
  input logic        en_ti64,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        mem_req_wide,
  input logic        dbm_wr_en,
  input logic [31:0] dbm_wr_data,
  input logic [31:0] dma_addr_lo,
  input logic [31:0] dma_addr_hi,
  input logic        sel_error,
  input logic        done
);
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wide)));
  assert_no_req_at_done_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req_valid);
  assert_lo_changes_with_done_R11: assert property (@(posedge clk) disable iff (rst)
    !$stable(dma_addr_lo) |-> done);
  assert_dbm_priority_R9: assert property (@(posedge clk) disable iff (rst)
    (dbm_wr_en && dbm_wr_data != 32'd0 && !en_40bit && !en_ti64) |=>
      (done && dma_addr_hi == $past(dbm_wr_data)));
  assert_sel_error_at_done_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_error) |-> done);
endmodule

bind bmove_addr_unit bmove_addr_unit_chk u_chk (
  .clk(clk), .rst(rst), .en_40bit(en_40bit), .en_ti64(en_ti64),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_req_wide(mem_req_wide),
  .dbm_wr_en(dbm_wr_en), .dbm_wr_data(dbm_wr_data),
  .dma_addr_lo(dma_addr_lo), .dma_addr_hi(dma_addr_hi),
  .sel_error(sel_error), .done(done)
);

// File: tb/bmove_addr_unit_tb.sv
module bmove_addr_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] insn_word = '0, addr_word = '0, script_ptr = '0, ds_base = '0;
  logic        en_40bit = 1'b0, en_ti64 = 1'b0, en_d64 = 1'b0;
  logic [2:0]  cur_phase = '0;
  logic [31:0] dbms_in = '0, sbms_in = '0;
  logic [4:0]  rf_sel;
  logic [31:0] rf_data;
  logic        mem_req_valid, mem_req_ready = 1'b0, mem_req_wide;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        dbm_wr_en;
  logic [31:0] dbm_wr_data, dma_addr_lo, dma_addr_hi, insn_addr, script_ptr_next;
  logic [23:0] byte_count;
  logic        phase_mismatch, sel_error, xfer_go, done;

  int checks = 0, errors = 0;
  logic [63:0] rsp_word = '0;
  int          req_cnt = 0;
  logic [31:0] req_addr_seen = '0;
  logic        req_wide_seen = 1'b0;
  logic        dbm_seen = 1'b0;
  logic [31:0] dbm_seen_data = '0;
  logic        go_seen = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [31:0] rf_val(input logic [4:0] s);
    return 32'hC000_0007 + 32'h0000_0101 * {27'd0, s};
  endfunction
  assign rf_data = rf_val(rf_sel);

  bmove_addr_unit u_dut (
    .clk(clk), .rst(rst), .start(start), .insn_word(insn_word),
    .addr_word(addr_word), .script_ptr(script_ptr), .ds_base(ds_base),
    .en_40bit(en_40bit), .en_ti64(en_ti64), .en_d64(en_d64),
    .cur_phase(cur_phase), .dbms_in(dbms_in), .sbms_in(sbms_in),
    .rf_sel(rf_sel), .rf_data(rf_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_wide(mem_req_wide),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .dbm_wr_en(dbm_wr_en), .dbm_wr_data(dbm_wr_data),
    .dma_addr_lo(dma_addr_lo), .dma_addr_hi(dma_addr_hi),
    .byte_count(byte_count), .insn_addr(insn_addr),
    .script_ptr_next(script_ptr_next), .phase_mismatch(phase_mismatch),
    .sel_error(sel_error), .xfer_go(xfer_go), .done(done)
  );

  // memory responder: ready one cycle after valid, data one cycle after accept
  initial begin
    forever begin
      @(negedge clk);
      if (mem_rsp_valid) mem_rsp_valid = 1'b0;
      if (mem_req_ready) begin
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rsp_word;
      end else if (mem_req_valid) begin
        mem_req_ready = 1'b1;
        req_cnt++;
        req_addr_seen = mem_req_addr;
        req_wide_seen = mem_req_wide;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (dbm_wr_en) begin
        dbm_seen = 1'b1;
        dbm_seen_data = dbm_wr_data;
      end
      if (xfer_go) go_seen = 1'b1;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_insn(input logic ind, input logic tab,
                                          input logic [2:0] ph, input logic [23:0] cnt);
    return {2'b00, ind, tab, 1'b0, ph, cnt};
  endfunction

  // issue one instruction; optionally drop en_40bit one cycle later (R12)
  task automatic run(input logic [31:0] iw, input logic [31:0] aw,
                     input logic [31:0] sp, input logic mode_flip);
    int wait_cyc;
    req_cnt = 0; dbm_seen = 1'b0; go_seen = 1'b0;
    @(negedge clk);
    insn_word = iw; addr_word = aw; script_ptr = sp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (mode_flip) begin
      en_40bit = 1'b0;
      cur_phase = cur_phase + 3'd1;
    end
    wait_cyc = 0;
    while (!done && wait_cyc < 100) begin
      @(negedge clk);
      wait_cyc++;
    end
    chk("R11 done within limit", {63'd0, done}, 64'd1);
  endtask

  task automatic t_reset;
    chk("R1 reset done",   {63'd0, done}, 64'd0);
    chk("R1 reset req",    {63'd0, mem_req_valid}, 64'd0);
    chk("R1 reset lo",     {32'd0, dma_addr_lo}, 64'd0);
    chk("R1 reset hi",     {32'd0, dma_addr_hi}, 64'd0);
    chk("R1 reset count",  {40'd0, byte_count}, 64'd0);
    chk("R1 reset flags",  {61'd0, phase_mismatch, sel_error, xfer_go}, 64'd0);
  endtask

  task automatic t_plain;
    cur_phase = 3'd1;
    run(mk_insn(0, 0, 3'd1, 24'h000123), 32'h8000_1000, 32'h200, 1'b0);
    chk("R2 plain lo",    {32'd0, dma_addr_lo}, 64'h8000_1000);
    chk("R2 plain count", {40'd0, byte_count}, 64'h123);
    chk("R2 plain no read", req_cnt, 0);
    chk("R9 plain hi zero", {32'd0, dma_addr_hi}, 64'd0);
    chk("R8 insn_addr", {32'd0, insn_addr}, 64'h1F8);
    chk("R8 sp unchanged", {32'd0, script_ptr_next}, 64'h200);
    chk("R10 go", {62'd0, go_seen, phase_mismatch}, 64'b10);
    @(negedge clk);
    chk("R11 done one cycle", {63'd0, done}, 64'd0);
  endtask

  task automatic t_priority;
    sbms_in = 32'h55;
    run(mk_insn(0, 0, 3'd1, 24'h10), 32'h100, 32'h300, 1'b0);
    chk("R9 static used", {32'd0, dma_addr_hi}, 64'h55);
    dbms_in = 32'h77;
    run(mk_insn(0, 0, 3'd1, 24'h10), 32'h100, 32'h300, 1'b0);
    chk("R9 dynamic over static", {32'd0, dma_addr_hi}, 64'h77);
    dbms_in = 32'h0; sbms_in = 32'h0;
  endtask

  task automatic t_direct64;
    en_d64 = 1'b1;
    rsp_word = 64'hFFFF_FFFF_1234_5678;
    run(mk_insn(0, 0, 3'd1, 24'h20), 32'h4000, 32'h400, 1'b0);
    chk("R8 third dword addr", {31'd0, req_wide_seen, req_addr_seen}, 64'h400);
    chk("R8 one read", req_cnt, 1);
    chk("R8 dbm write", {31'd0, dbm_seen, dbm_seen_data}, 64'h1_1234_5678);
    chk("R9 fetched high", {32'd0, dma_addr_hi}, 64'h1234_5678);
    chk("R8 sp advanced", {32'd0, script_ptr_next}, 64'h404);
    chk("R8 insn addr minus 12", {32'd0, insn_addr}, 64'h404 - 64'd12);
    sbms_in = 32'h66; dbms_in = 32'h99;
    rsp_word = 64'h0;
    run(mk_insn(0, 0, 3'd1, 24'h20), 32'h4000, 32'h500, 1'b0);
    chk("R9 zero third dword falls to static", {32'd0, dma_addr_hi}, 64'h66);
    sbms_in = 32'h0; dbms_in = 32'h0;
  endtask

  task automatic t_indirect;
    rsp_word = 64'h1111_2222_DEAD_BEE0;
    run(mk_insn(1, 1, 3'd1, 24'h33), 32'h3000, 32'h600, 1'b0);
    chk("R3 read addr narrow", {31'd0, req_wide_seen, req_addr_seen}, 64'h3000);
    chk("R3 one read", req_cnt, 1);
    chk("R3 lo from pointer", {32'd0, dma_addr_lo}, 64'hDEAD_BEE0);
    chk("R2 count from insn", {40'd0, byte_count}, 64'h33);
    chk("R8 no advance when indirect", {32'd0, script_ptr_next}, 64'h600);
    en_d64 = 1'b0;
  endtask

  task automatic t_table;
    ds_base = 32'h1000;
    rsp_word = {32'h9000_0040, 32'hAB00_0040};
    run(mk_insn(0, 1, 3'd1, 24'h7), 32'h55FF_FFF0, 32'h700, 1'b0);
    chk("R4 negative offset wide", {31'd0, req_wide_seen, req_addr_seen}, 64'h1_0000_0FF0);
    chk("R4 count from entry", {40'd0, byte_count}, 64'h40);
    chk("R4 lo from entry", {32'd0, dma_addr_lo}, 64'h9000_0040);
    chk("R9 table no modes hi", {32'd0, dma_addr_hi}, 64'd0);
    run(mk_insn(0, 1, 3'd1, 24'h7), 32'h0000_0010, 32'h700, 1'b0);
    chk("R4 positive offset", {32'd0, req_addr_seen}, 64'h1010);
    en_40bit = 1'b1;
    run(mk_insn(0, 1, 3'd1, 24'h7), 32'h0000_0010, 32'h700, 1'b0);
    chk("R5 high byte", {32'd0, dma_addr_hi}, 64'hAB);
    en_40bit = 1'b0;
  endtask

  task automatic t_ti64;
    en_ti64 = 1'b1;
    rsp_word = {32'h8000_0000, 32'h0300_0010};
    run(mk_insn(0, 1, 3'd1, 24'h7), 32'h20, 32'h800, 1'b0);
    chk("R6 selector 3", {32'd0, dma_addr_hi}, {32'd0, rf_val(5'h03)});
    chk("R6 no error", {63'd0, sel_error}, 64'd0);
    rsp_word = {32'h8000_0100, 32'hF500_0010};
    run(mk_insn(0, 1, 3'd1, 24'h7), 32'h20, 32'h800, 1'b0);
    chk("R6 selector 0x15 masked", {32'd0, dma_addr_hi}, {32'd0, rf_val(5'h15)});
    rsp_word = {32'h8000_0200, 32'h1F00_0008};
    run(mk_insn(0, 1, 3'd1, 24'h7), 32'h20, 32'h800, 1'b0);
    chk("R7 illegal flag", {63'd0, sel_error}, 64'd1);
    chk("R7 high kept", {32'd0, dma_addr_hi}, {32'd0, rf_val(5'h15)});
    chk("R7 lo still formed", {32'd0, dma_addr_lo}, 64'h8000_0200);
    rsp_word = {32'h8000_0300, 32'h1000_0008};
    run(mk_insn(0, 1, 3'd1, 24'h7), 32'h20, 32'h800, 1'b0);
    chk("R7 cleared by legal", {63'd0, sel_error}, 64'd0);
    chk("R6 selector 0x10", {32'd0, dma_addr_hi}, {32'd0, rf_val(5'h10)});
    en_ti64 = 1'b0;
  endtask

  task automatic t_phase;
    cur_phase = 3'd2;
    run(mk_insn(0, 0, 3'd3, 24'h5), 32'h900, 32'h900, 1'b0);
    chk("R10 mismatch flag", {63'd0, phase_mismatch}, 64'd1);
    chk("R10 no go", {63'd0, go_seen}, 64'd0);
    cur_phase = 3'd3;
    run(mk_insn(0, 0, 3'd3, 24'h5), 32'h900, 32'h900, 1'b0);
    chk("R10 match clears", {62'd0, go_seen, phase_mismatch}, 64'b10);
  endtask

  task automatic t_sampled;
    en_40bit = 1'b1; cur_phase = 3'd1;
    rsp_word = {32'h7000_0000, 32'h5C00_0010};
    run(mk_insn(0, 1, 3'd1, 24'h9), 32'h0, 32'hA00, 1'b1);
    chk("R12 mode held", {32'd0, dma_addr_hi}, 64'h5C);
    chk("R12 phase held", {63'd0, phase_mismatch}, 64'd0);
    en_40bit = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_plain;
    t_priority;
    t_direct64;
    t_indirect;
    t_table;
    t_ti64;
    t_phase;
    t_sampled;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 20000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule